// File: doc/BRIEF.md
# Masked ASID-Tagged Translation Buffer Array

This block is the storage and search part of a fully associative address translation buffer. Each of its `ENTRIES` slots maps one pair of neighbouring virtual pages, an even page and an odd page, onto two separate physical frames. Every slot also carries its own page-size mask, so one slot can cover a large region while the slot beside it covers a single small page. Each slot is tagged with an 8-bit address-space identifier. A global flag in a slot lets every address space share that translation.

A search key, made of a virtual page number and an identifier, is compared against all slots at once. The combinational result gives four things:
- a hit flag;
- the index of the matching slot, which is what a probe returns;
- a flag for more than one match;
- the two page-half words of the winning slot.

Software-style maintenance works through three controls:
- an indexed slot write, taking effect at the next clock edge;
- a flush of the whole table;
- a read port that always shows the slot under a round-robin pointer, with a strobe that steps the pointer on.

Choosing between the even and odd half, building the physical address and raising faults all belong to the consumer of this block.

The block holds no sequencing state beyond its storage and the pointer. It has two operating conditions. The first is *reset/flushed*, where every slot is empty and the pointer is 0. The second is *populated*, where slots may be live. An in-range write moves the block from reset/flushed to populated. Reset or flush takes it back from any condition.

Top module: `tlbx_array`

## Requirements
- R1: After reset every slot reads back as all zeros, the pointer is 0, and no search key hits.
- R2: A slot matches a key only when the key page number and the slot page number agree in every bit where the slot mask is 0. Bits where the mask is 1 are ignored.
- R3: A slot matches only if its global flag is set or the key identifier equals the slot identifier. The global flag is stored as the AND of bit 0 of both written half words.
- R4: A slot whose two valid bits (bit 1 of each half word) are both clear is empty and never matches.
- R5: When several slots match, the lowest index wins and `lk_multi` is 1. With exactly one match, `lk_multi` is 0.
- R6: On a miss, `lk_hit` is 0, `lk_idx` is all ones and `lk_multi` is 0.
- R7: A write with `wr_idx` below `ENTRIES` replaces that slot at the next rising clock edge. Readback packing is as follows:
  - a half word is frame<<6 | attr<<3 | dirty<<2 | valid<<1 | global;
  - `rd_hi` is page<<11 | identifier;
  - `rd_mask` is mask<<11.
- R8: A write with `wr_idx` at or above `ENTRIES` changes no slot.
- R9: Flush clears every slot to zero and sets the pointer to 0 at the next edge. It takes precedence over a write and over a pointer step issued in the same cycle.
- R10: `rd_adv` steps the pointer by one at the next edge. After `ENTRIES-1` the pointer wraps to 0.
- R11: On a hit, `lk_lo0` and `lk_lo1` show the winning slot's half words in R7 packing. On a miss, both are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vpn | input | VPN_W | Search key page number |
| lk_asid | input | ASID_W | Search key identifier |
| lk_hit | output | 1 | Some slot matches the key |
| lk_multi | output | 1 | More than one slot matches |
| lk_idx | output | IDX_W | Lowest matching index, all ones on miss |
| lk_lo0 | output | LO_W | Even half word of the winning slot |
| lk_lo1 | output | LO_W | Odd half word of the winning slot |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDX_W+1 | Target slot; out-of-range values are dropped |
| wr_vpn | input | VPN_W | Page number to store |
| wr_mask | input | VPN_W | Page mask to store (1 = ignore bit) |
| wr_asid | input | ASID_W | Identifier to store |
| wr_lo0 | input | LO_W | Even half word, R7 packing |
| wr_lo1 | input | LO_W | Odd half word, R7 packing |
| flush | input | 1 | Clear all slots and the pointer |
| rd_adv | input | 1 | Step the round-robin pointer |
| rd_idx | output | IDX_W | Current pointer value |
| rd_hi | output | VPN_W+11 | Page and identifier of the slot at the pointer |
| rd_mask | output | VPN_W+11 | Mask of the slot at the pointer, shifted by 11 |
| rd_lo0 | output | LO_W | Even half word of the slot at the pointer |
| rd_lo1 | output | LO_W | Odd half word of the slot at the pointer |

## Verification
The assertions check the following on every cycle:
- a hit never names an empty slot;
- a multiple-match flag never appears without a hit;
- a miss always shows the all-ones index with zero half words;
- a dropped write leaves slot liveness unchanged;
- a flush empties the table and zeroes the pointer;
- the pointer wraps after the last slot.

Only the bench scenarios can show that the masked compare, the identifier/global rule and the lowest-index priority give the right slot for every key. The bench sweeps every page number under several identifiers against overlapping, masked and empty slots. Only the bench can also confirm that the bit packing of stored words is right, and that flush wins over a simultaneous write.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
    // bit position of the page number inside the packed high word and mask word
    localparam int TLBX_HI_POS    = 11;
    // width of the cache attribute field in a half word
    localparam int TLBX_ATTR_W    = 3;
    // number of flag/attribute bits below the frame number in a half word
    localparam int TLBX_LO_FLAGS  = TLBX_ATTR_W + 3;

    typedef enum logic [1:0] {
        TLBX_NONE = 2'd0,
        TLBX_ONE  = 2'd1,
        TLBX_MANY = 2'd2
    } tlbx_match_e;
endpackage

// File: rtl/tlbx_cmp.sv
module tlbx_cmp #(
    parameter int VPN_W  = 12,
    parameter int ASID_W = 8
) (
    input  logic [VPN_W-1:0]  key_vpn,
    input  logic [ASID_W-1:0] key_asid,
    input  logic [VPN_W-1:0]  e_vpn,
    input  logic [VPN_W-1:0]  e_mask,
    input  logic [ASID_W-1:0] e_asid,
    input  logic              e_glob,
    input  logic              e_live,
    output logic              hit
);
    logic vpn_eq;
    logic asid_ok;

    // compare only the bits the slot mask leaves exposed
    assign vpn_eq  = ((key_vpn ^ e_vpn) & ~e_mask) == '0;
    assign asid_ok = e_glob | (key_asid == e_asid);
    assign hit     = e_live & vpn_eq & asid_ok;
endmodule

// File: rtl/tlbx_pick.sv
module tlbx_pick
    import tlbx_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     hits,
    output logic [IDX_W-1:0] first,
    output tlbx_match_e      kind
);
    logic several;

    // clearing the lowest set bit leaves something only when two or more are set
    assign several = (hits & (hits - N'(1))) != '0;

    always_comb begin
        first = '1;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) first = IDX_W'(i);
        end
    end

    always_comb begin
        unique case ({|hits, several})
            2'b10:   kind = TLBX_ONE;
            2'b11:   kind = TLBX_MANY;
            default: kind = TLBX_NONE;
        endcase
    end
endmodule

// File: rtl/tlbx_rrptr.sv
module tlbx_rrptr #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          ptr <= '0;
        else if (flush)      ptr <= '0;
        else if (adv)        ptr <= (ptr == LAST) ? '0 : ptr + IDX_W'(1);
    end

    // R10
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !flush && ptr == LAST) |=> (ptr == '0));
    // R10
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LAST);
    // R9
    ptr_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ptr == '0));
endmodule

// File: rtl/tlbx_array.sv
module tlbx_array
    import tlbx_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 12,
    parameter int ASID_W  = 8,
    parameter int PFN_W   = 12,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int WI_W   = IDX_W + 1,
    localparam int HI_W   = VPN_W + TLBX_HI_POS,
    localparam int LO_W   = PFN_W + TLBX_LO_FLAGS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic              lk_multi,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [LO_W-1:0]   lk_lo0,
    output logic [LO_W-1:0]   lk_lo1,
    input  logic              wr_en,
    input  logic [WI_W-1:0]   wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [VPN_W-1:0]  wr_mask,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [LO_W-1:0]   wr_lo0,
    input  logic [LO_W-1:0]   wr_lo1,
    input  logic              flush,
    input  logic              rd_adv,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [HI_W-1:0]   rd_hi,
    output logic [HI_W-1:0]   rd_mask,
    output logic [LO_W-1:0]   rd_lo0,
    output logic [LO_W-1:0]   rd_lo1
);
    // slot storage; bit 0 of each half word holds the shared global flag
    logic [VPN_W-1:0]  vpn_q  [ENTRIES];
    logic [VPN_W-1:0]  mask_q [ENTRIES];
    logic [ASID_W-1:0] asid_q [ENTRIES];
    logic [LO_W-1:0]   lo0_q  [ENTRIES];
    logic [LO_W-1:0]   lo1_q  [ENTRIES];

    logic [ENTRIES-1:0] live;
    logic [ENTRIES-1:0] hits;
    logic               wr_ok;
    logic               glob_in;
    tlbx_match_e        match_kind;

    assign wr_ok   = wr_idx < WI_W'(ENTRIES);
    assign glob_in = wr_lo0[0] & wr_lo1[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                vpn_q[i] <= '0; mask_q[i] <= '0; asid_q[i] <= '0;
                lo0_q[i] <= '0; lo1_q[i]  <= '0;
            end
        end else if (flush) begin
            for (int i = 0; i < ENTRIES; i++) begin
                vpn_q[i] <= '0; mask_q[i] <= '0; asid_q[i] <= '0;
                lo0_q[i] <= '0; lo1_q[i]  <= '0;
            end
        end else if (wr_en && wr_ok) begin
            vpn_q[wr_idx[IDX_W-1:0]]  <= wr_vpn;
            mask_q[wr_idx[IDX_W-1:0]] <= wr_mask;
            asid_q[wr_idx[IDX_W-1:0]] <= wr_asid;
            lo0_q[wr_idx[IDX_W-1:0]]  <= {wr_lo0[LO_W-1:1], glob_in};
            lo1_q[wr_idx[IDX_W-1:0]]  <= {wr_lo1[LO_W-1:1], glob_in};
        end
    end

    // one comparator per slot
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        assign live[g] = lo0_q[g][1] | lo1_q[g][1];
        tlbx_cmp #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_cmp (
            .key_vpn (lk_vpn),
            .key_asid(lk_asid),
            .e_vpn   (vpn_q[g]),
            .e_mask  (mask_q[g]),
            .e_asid  (asid_q[g]),
            .e_glob  (lo0_q[g][0]),
            .e_live  (live[g]),
            .hit     (hits[g])
        );
    end

    tlbx_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
        .hits (hits),
        .first(lk_idx),
        .kind (match_kind)
    );

    assign lk_hit   = match_kind != TLBX_NONE;
    assign lk_multi = match_kind == TLBX_MANY;
    assign lk_lo0   = lk_hit ? lo0_q[lk_idx] : '0;
    assign lk_lo1   = lk_hit ? lo1_q[lk_idx] : '0;

    tlbx_rrptr #(.N(ENTRIES), .IDX_W(IDX_W)) u_ptr (
        .clk  (clk),
        .rst_n(rst_n),
        .flush(flush),
        .adv  (rd_adv),
        .ptr  (rd_idx)
    );

    assign rd_hi   = {vpn_q[rd_idx], {(TLBX_HI_POS - ASID_W){1'b0}}, asid_q[rd_idx]};
    assign rd_mask = {mask_q[rd_idx], {TLBX_HI_POS{1'b0}}};
    assign rd_lo0  = lo0_q[rd_idx];
    assign rd_lo1  = lo1_q[rd_idx];

    // R4
    hit_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> live[lk_idx]);
    // R5
    multi_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_multi |-> lk_hit);
    // R6
    miss_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_idx == '1 && lk_lo0 == '0 && lk_lo1 == '0 && !lk_multi));
    // R8
    wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ok && !flush) |=> $stable(live));
    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (live == '0));
endmodule

// File: tb/tlbx_array_tb.sv
module tlbx_array_tb_top;
    localparam int N  = 8;
    localparam int VW = 12;
    localparam int AW = 8;
    localparam int PW = 12;
    localparam int IW = 3;
    localparam int LW = PW + 6;
    localparam int HW = VW + 11;

    logic clk = 0;
    logic rst_n = 0;
    always #5 clk = ~clk;

    logic [VW-1:0] lk_vpn = '0;
    logic [AW-1:0] lk_asid = '0;
    logic lk_hit, lk_multi;
    logic [IW-1:0] lk_idx;
    logic [LW-1:0] lk_lo0, lk_lo1;
    logic wr_en = 0;
    logic [IW:0] wr_idx = '0;
    logic [VW-1:0] wr_vpn = '0, wr_mask = '0;
    logic [AW-1:0] wr_asid = '0;
    logic [LW-1:0] wr_lo0 = '0, wr_lo1 = '0;
    logic flush = 0, rd_adv = 0;
    logic [IW-1:0] rd_idx;
    logic [HW-1:0] rd_hi, rd_mask;
    logic [LW-1:0] rd_lo0, rd_lo1;

    tlbx_array #(.ENTRIES(N), .VPN_W(VW), .ASID_W(AW), .PFN_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_hit(lk_hit), .lk_multi(lk_multi),
        .lk_idx(lk_idx), .lk_lo0(lk_lo0), .lk_lo1(lk_lo1),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_mask(wr_mask),
        .wr_asid(wr_asid), .wr_lo0(wr_lo0), .wr_lo1(wr_lo1),
        .flush(flush), .rd_adv(rd_adv), .rd_idx(rd_idx), .rd_hi(rd_hi),
        .rd_mask(rd_mask), .rd_lo0(rd_lo0), .rd_lo1(rd_lo1)
    );

    // reference model of the slots, built from the requirements
    logic [VW-1:0] m_vpn [N];
    logic [VW-1:0] m_mask [N];
    logic [AW-1:0] m_asid [N];
    logic [LW-1:0] m_lo0 [N];
    logic [LW-1:0] m_lo1 [N];

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    function automatic logic [LW-1:0] mk_lo(input logic [PW-1:0] p, input logic [2:0] c,
                                           input logic d, input logic v, input logic g);
        return {p, c, d, v, g};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin
            m_vpn[i] = '0; m_mask[i] = '0; m_asid[i] = '0; m_lo0[i] = '0; m_lo1[i] = '0;
        end
    endtask

    task automatic wr(input int idx, input logic [VW-1:0] v, input logic [VW-1:0] m,
                      input logic [AW-1:0] a, input logic [LW-1:0] l0, input logic [LW-1:0] l1);
        logic g;
        @(negedge clk);
        wr_en = 1; wr_idx = (IW+1)'(idx); wr_vpn = v; wr_mask = m; wr_asid = a;
        wr_lo0 = l0; wr_lo1 = l1;
        @(negedge clk);
        wr_en = 0;
        if (idx < N) begin
            g = l0[0] & l1[0];
            m_vpn[idx] = v; m_mask[idx] = m; m_asid[idx] = a;
            m_lo0[idx] = {l0[LW-1:1], g}; m_lo1[idx] = {l1[LW-1:1], g};
        end
    endtask

    task automatic expect_lk(input logic [VW-1:0] v, input logic [AW-1:0] a,
                             output logic [2*LW+4:0] e);
        logic h, mu, live;
        logic [IW-1:0] ix;
        logic [LW-1:0] e0, e1;
        h = 0; mu = 0; ix = '1; e0 = '0; e1 = '0;
        for (int i = 0; i < N; i++) begin
            live = m_lo0[i][1] | m_lo1[i][1];
            if (live && (((v ^ m_vpn[i]) & ~m_mask[i]) == '0) && (m_lo0[i][0] || a == m_asid[i])) begin
                if (h) mu = 1;
                else begin h = 1; ix = i[IW-1:0]; e0 = m_lo0[i]; e1 = m_lo1[i]; end
            end
        end
        e = {h, mu, ix, e0, e1};
    endtask

    task automatic look(input string tag, input logic [VW-1:0] v, input logic [AW-1:0] a);
        logic [2*LW+4:0] e;
        lk_vpn = v; lk_asid = a;
        #1;
        expect_lk(v, a, e);
        chk(tag, 64'({lk_hit, lk_multi, lk_idx, lk_lo0, lk_lo1}), 64'(e));
        #1;
    endtask

    task automatic readback_all(input string tag);
        for (int i = 0; i < N; i++) begin
            chk({tag, " R10 ptr"}, 64'(rd_idx), 64'(i));
            chk({tag, " R7 hi"}, 64'(rd_hi), 64'({m_vpn[i], 3'b000, m_asid[i]}));
            chk({tag, " R7 mask"}, 64'(rd_mask), 64'({m_mask[i], 11'b0}));
            chk({tag, " R7 lo"}, 64'({rd_lo0, rd_lo1}), 64'({m_lo0[i], m_lo1[i]}));
            @(negedge clk); rd_adv = 1;
            @(negedge clk); rd_adv = 0;
        end
        chk({tag, " R10 wrap"}, 64'(rd_idx), 64'(0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog act=timeout exp=finished");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ptr", 64'(rd_idx), 64'(0));
        look("R1 no hit", 12'h000, 8'h00);
        readback_all("R1");

        wr(0, 12'h120, 12'h000, 8'd5, mk_lo(12'hA01, 3'd2, 1, 1, 0), mk_lo(12'hA02, 3'd3, 0, 0, 0));
        wr(1, 12'h300, 12'h0FF, 8'd7, mk_lo(12'hB01, 3'd3, 1, 1, 1), mk_lo(12'hB02, 3'd2, 1, 1, 1));
        wr(2, 12'h120, 12'h000, 8'd9, mk_lo(12'hC01, 3'd1, 0, 1, 0), mk_lo(12'hC02, 3'd0, 1, 0, 0));
        wr(3, 12'h340, 12'h03F, 8'd7, mk_lo(12'hD01, 3'd4, 1, 1, 0), mk_lo(12'hD02, 3'd5, 0, 1, 1));
        wr(4, 12'h500, 12'h000, 8'd5, mk_lo(12'hE01, 3'd6, 1, 0, 1), mk_lo(12'hE02, 3'd7, 1, 0, 1));
        wr(5, 12'h600, 12'h001, 8'd5, mk_lo(12'hF01, 3'd2, 0, 0, 0), mk_lo(12'hF02, 3'd3, 1, 1, 0));
        wr(6, 12'h123, 12'h003, 8'd5, mk_lo(12'h111, 3'd1, 1, 1, 0), mk_lo(12'h112, 3'd1, 1, 1, 0));
        // R8 out-of-range writes are dropped
        wr(8, 12'h700, 12'h000, 8'd5, mk_lo(12'h777, 3'd1, 1, 1, 1), mk_lo(12'h778, 3'd1, 1, 1, 1));
        wr(15, 12'h700, 12'h000, 8'd5, mk_lo(12'h779, 3'd1, 1, 1, 1), mk_lo(12'h77A, 3'd1, 1, 1, 1));
        look("R8 dropped write no hit", 12'h700, 8'd5);
        chk("R8 dropped write", 64'(lk_hit), 64'(0));

        // targeted cases
        lk_vpn = 12'h3AB; lk_asid = 8'd3; #1;
        chk("R3 global slot hit", 64'({lk_hit, lk_idx}), 64'({1'b1, 3'd1})); #1;
        lk_vpn = 12'h345; lk_asid = 8'd7; #1;
        chk("R5 lowest index multi", 64'({lk_hit, lk_multi, lk_idx}), 64'({2'b11, 3'd1})); #1;
        lk_vpn = 12'h345; lk_asid = 8'd3; #1;
        chk("R3 asid mismatch single", 64'({lk_hit, lk_multi, lk_idx}), 64'({2'b10, 3'd1})); #1;
        lk_vpn = 12'h500; lk_asid = 8'd5; #1;
        chk("R4 empty slot", 64'(lk_hit), 64'(0)); #1;
        lk_vpn = 12'h800; lk_asid = 8'd5; #1;
        chk("R6 miss idx", 64'({lk_hit, lk_multi, lk_idx}), 64'({2'b00, 3'b111})); #1;
        lk_vpn = 12'h601; lk_asid = 8'd5; #1;
        chk("R2 masked bit", 64'({lk_hit, lk_idx}), 64'({1'b1, 3'd5})); #1;
        lk_vpn = 12'h602; lk_asid = 8'd5; #1;
        chk("R2 unmasked bit", 64'(lk_hit), 64'(0)); #1;
        lk_vpn = 12'h120; lk_asid = 8'd9; #1;
        chk("R11 lo words", 64'({lk_lo0, lk_lo1}), 64'({mk_lo(12'hC01, 3'd1, 0, 1, 0), mk_lo(12'hC02, 3'd0, 1, 0, 0)})); #1;

        // full sweep of page numbers under several identifiers: R2 R3 R4 R5 R6 R11
        for (int v = 0; v < 4096; v++) begin
            look("R2 R3 R5 R6 R11 sweep", 12'(v), 8'd5);
            look("R2 R3 R5 R6 R11 sweep", 12'(v), 8'd7);
            look("R2 R3 R5 R6 R11 sweep", 12'(v), 8'd9);
            look("R2 R3 R5 R6 R11 sweep", 12'(v), 8'd3);
        end

        readback_all("R7");

        // R9 flush beats a write and a pointer step in the same cycle
        repeat (3) begin
            @(negedge clk); rd_adv = 1;
            @(negedge clk); rd_adv = 0;
        end
        chk("R10 ptr step", 64'(rd_idx), 64'(3));
        @(negedge clk);
        flush = 1; rd_adv = 1; wr_en = 1; wr_idx = 4'd7; wr_vpn = 12'h123; wr_mask = '0;
        wr_asid = 8'd5; wr_lo0 = mk_lo(12'h999, 3'd1, 1, 1, 1); wr_lo1 = wr_lo0;
        @(negedge clk);
        flush = 0; rd_adv = 0; wr_en = 0;
        model_clear();
        chk("R9 ptr cleared", 64'(rd_idx), 64'(0));
        look("R9 flushed miss", 12'h123, 8'd5);
        look("R9 flushed miss", 12'h3AB, 8'd3);
        readback_all("R9");

        done = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule